// File: doc/BRIEF.md
# Banded Raster Fetch Address Generator

This block produces the byte fetch addresses for a raster display whose every line is 40 bytes wide. The screen is split vertically into three equal bands. All three bands share one set of memory rows, and those rows start 128 bytes apart. The bands differ only in which 40-byte slice of each row they read:

- the top band reads offsets 0..39;
- the middle band reads offsets 40..79;
- the bottom band reads offsets 80..119.

With this layout the line address is a shift plus a choice among three constants, so no multiply by 40 is needed.

The block sits between the display timing logic and the frame memory. Timing supplies three inputs: a pixel clock enable, a frame-start pulse and the active-display window. Each cycle in which both the enable and the window are high requests one byte. The generator then presents the address of that byte, a fetch strobe and the band number, all registered. It then steps to the next byte, the next line, and the next band. With the default parameters, 192 lines map onto 64 rows of 128 bytes, which is 8 KiB.

Top module: `tband_addr_gen`

## Requirements
- R1: While `rst_n` is low, `mem_addr`, `band_idx` and `fetch_stb` are all 0.
- R2: `fetch_stb` is high in the cycle after a clock edge at which `pix_en` and `active` were both high and `frame_start` was low. It is low after every other edge.
- R3: A presented fetch has `mem_addr` = row*128 + band*40 + col. Here col runs 0..39 and steps by one on each fetch.
- R4: The fetch after col 39 starts the next line: col returns to 0 and row rises by one.
- R5: After row 63 of a band, row returns to 0 and the band advances (band 0 to band 1, band 1 to band 2). The band offsets are 0, 40 and 80, and `band_idx` gives the band (0, 1 or 2) of the presented fetch.
- R6: After the last byte of band 2 (address 8183), the next fetch is address 0 in band 0.
- R7: `frame_start` returns col, row and band to 0. It takes priority over a fetch request in the same cycle, so no strobe follows that edge.
- R8: After an edge with no fetch, `mem_addr` and `band_idx` keep their previous values. Cycles with `pix_en` or `active` low do not advance the position.
- R9: The low 7 address bits never exceed 119, so row offsets 120..127 are never addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_en | input | 1 | Pixel clock enable; one byte per enabled cycle |
| frame_start | input | 1 | Start-of-frame pulse; resets the position |
| active | input | 1 | Active-display window |
| mem_addr | output | 13 | Byte address of the presented fetch |
| fetch_stb | output | 1 | Fetch strobe; `mem_addr` is valid while high |
| band_idx | output | 2 | Band of the presented fetch |

## Verification
Two events can fall in the same cycle.

- **End of a band.** A single fetch can end a line and a band together, so the row wrap and the band advance happen at the same edge. An unbroken full frame provokes this at fetches 2560 and 5120, and at the frame end, where the band also wraps from 2 to 0. Each fetch is judged against an address computed independently in the bench.
- **Frame start against a fetch.** `frame_start` is raised together with `pix_en` and `active` in the middle of a line. The bench expects no strobe and a held address after that edge, and expects address 0 on the following fetch.

// File: rtl/tband_pkg.sv
package tband_pkg;
  localparam int unsigned DEF_LINE_BYTES = 40;
  localparam int unsigned DEF_ROW_STRIDE = 128;
  localparam int unsigned DEF_BAND_ROWS  = 64;
  localparam int unsigned DEF_NUM_BANDS  = 3;

  // Start offset of a band's slice inside a memory row.
  function automatic int unsigned band_base(int unsigned band, int unsigned line_bytes);
    return band * line_bytes;
  endfunction
endpackage

// File: rtl/tband_col_ctr.sv
module tband_col_ctr #(
  parameter int unsigned LINE_BYTES = 40,
  parameter int unsigned COL_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_BYTES - 1);

  logic [COL_W-1:0] col_q, col_d;

  assign last_o = (col_q == COL_LAST);
  assign col_o  = col_q;

  always_comb begin
    col_d = col_q;
    if (clr) begin
      col_d = '0;
    end else if (adv) begin
      col_d = last_o ? '0 : col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else begin
      col_q <= col_d;
    end
  end

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_LAST);

  // R4
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_o) |=> (col_q == '0));
endmodule

// File: rtl/tband_rowband_ctr.sv
module tband_rowband_ctr #(
  parameter int unsigned BAND_ROWS = 64,
  parameter int unsigned NUM_BANDS = 3,
  parameter int unsigned ROW_W     = 6,
  parameter int unsigned BAND_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clr,
  output logic [ROW_W-1:0]  row_o,
  output logic [BAND_W-1:0] band_o
);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(BAND_ROWS - 1);
  localparam logic [BAND_W-1:0] BAND_LAST = BAND_W'(NUM_BANDS - 1);

  logic [ROW_W-1:0]  row_q, row_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic              row_last, band_last;

  assign row_last  = (row_q == ROW_LAST);
  assign band_last = (band_q == BAND_LAST);
  assign row_o     = row_q;
  assign band_o    = band_q;

  always_comb begin
    row_d  = row_q;
    band_d = band_q;
    if (clr) begin
      row_d  = '0;
      band_d = '0;
    end else if (adv) begin
      if (row_last) begin
        row_d  = '0;
        band_d = band_last ? '0 : band_q + 1'b1;
      end else begin
        row_d  = row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      band_q <= '0;
    end else begin
      row_q  <= row_d;
      band_q <= band_d;
    end
  end

  // R5
  band_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    band_q <= BAND_LAST);

  // R5
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && row_last) |=> (row_q == '0));

  // R6
  band_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && row_last && band_last) |=> (band_q == '0));
endmodule

// File: rtl/tband_addr_fmt.sv
module tband_addr_fmt #(
  parameter int unsigned LINE_BYTES = 40,
  parameter int unsigned NUM_BANDS  = 3,
  parameter int unsigned ROW_W      = 6,
  parameter int unsigned BAND_W     = 2,
  parameter int unsigned COL_W      = 6,
  parameter int unsigned OFS_W      = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [BAND_W-1:0]      band_i,
  input  logic [COL_W-1:0]       col_i,
  output logic [ROW_W+OFS_W-1:0] addr_o,
  output logic                   stb_o,
  output logic [BAND_W-1:0]      band_o
);
  import tband_pkg::*;

  localparam int unsigned ADDR_W   = ROW_W + OFS_W;
  localparam int unsigned USED_OFS = NUM_BANDS * LINE_BYTES;

  logic [OFS_W-1:0]  base_tab [NUM_BANDS];
  logic [OFS_W-1:0]  base_sel;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic              stb_q, stb_d;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_base
    assign base_tab[b] = OFS_W'(band_base(b, LINE_BYTES));
  end

  always_comb begin
    base_sel = '0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (band_i == BAND_W'(b)) base_sel = base_tab[b];
    end
  end

  always_comb begin
    addr_d = addr_q;
    band_d = band_q;
    stb_d  = fire;
    if (fire) begin
      addr_d = {row_i, base_sel + OFS_W'(col_i)};
      band_d = band_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      band_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      band_q <= band_d;
      stb_q  <= stb_d;
    end
  end

  assign addr_o = addr_q;
  assign band_o = band_q;
  assign stb_o  = stb_q;

  // R9
  row_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[OFS_W-1:0] < OFS_W'(USED_OFS));
endmodule

// File: rtl/tband_addr_gen.sv
module tband_addr_gen #(
  parameter  int unsigned LINE_BYTES = tband_pkg::DEF_LINE_BYTES,
  parameter  int unsigned ROW_STRIDE = tband_pkg::DEF_ROW_STRIDE,
  parameter  int unsigned BAND_ROWS  = tband_pkg::DEF_BAND_ROWS,
  parameter  int unsigned NUM_BANDS  = tband_pkg::DEF_NUM_BANDS,
  localparam int unsigned COL_W      = $clog2(LINE_BYTES),
  localparam int unsigned ROW_W      = $clog2(BAND_ROWS),
  localparam int unsigned BAND_W     = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1,
  localparam int unsigned OFS_W      = $clog2(ROW_STRIDE),
  localparam int unsigned ADDR_W     = ROW_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              frame_start,
  input  logic              active,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fetch_stb,
  output logic [BAND_W-1:0] band_idx
);
  logic             fire;
  logic             col_last;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [BAND_W-1:0] band;

  // Frame start outranks a fetch request in the same cycle.
  assign fire = pix_en & active & ~frame_start;

  tband_col_ctr #(
    .LINE_BYTES(LINE_BYTES),
    .COL_W     (COL_W)
  ) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fire),
    .clr   (frame_start),
    .col_o (col),
    .last_o(col_last)
  );

  tband_rowband_ctr #(
    .BAND_ROWS(BAND_ROWS),
    .NUM_BANDS(NUM_BANDS),
    .ROW_W    (ROW_W),
    .BAND_W   (BAND_W)
  ) u_rowband (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fire & col_last),
    .clr   (frame_start),
    .row_o (row),
    .band_o(band)
  );

  tband_addr_fmt #(
    .LINE_BYTES(LINE_BYTES),
    .NUM_BANDS (NUM_BANDS),
    .ROW_W     (ROW_W),
    .BAND_W    (BAND_W),
    .COL_W     (COL_W),
    .OFS_W     (OFS_W)
  ) u_fmt (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .row_i (row),
    .band_i(band),
    .col_i (col),
    .addr_o(mem_addr),
    .stb_o (fetch_stb),
    .band_o(band_idx)
  );

  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> $past(pix_en && active && !frame_start));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |-> ($stable(mem_addr) && $stable(band_idx)));

  // R7
  frame_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !fetch_stb);

  initial begin
    assert (NUM_BANDS * LINE_BYTES <= ROW_STRIDE);
    assert ((1 << OFS_W) == ROW_STRIDE);
  end
endmodule

// File: tb/sim_tband_addr_gen.sv
module sim_tband_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en, frame_start, active;
  logic [12:0] mem_addr;
  logic        fetch_stb;
  logic [1:0]  band_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int m_row, m_band, m_col;
  int exp_addr, exp_band, exp_stb;

  always #4 clk = ~clk;

  tband_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .frame_start(frame_start),
    .active(active), .mem_addr(mem_addr), .fetch_stb(fetch_stb), .band_idx(band_idx)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(string req);
    chk({req, " stb"},  int'(fetch_stb), exp_stb);
    chk({req, " addr"}, int'(mem_addr),  exp_addr);
    chk({req, " band"}, int'(band_idx),  exp_band);
  endtask

  // Drive one cycle and update the bench model for that edge.
  task automatic step(bit pe, bit act, bit fs);
    @(negedge clk);
    pix_en = pe; active = act; frame_start = fs;
    @(posedge clk);
    #2;
    if (fs) begin
      m_row = 0; m_band = 0; m_col = 0; exp_stb = 0;
    end else if (pe && act) begin
      exp_stb  = 1;
      exp_addr = m_row * 128 + m_band * 40 + m_col;
      exp_band = m_band;
      if (m_col == 39) begin
        m_col = 0;
        if (m_row == 63) begin
          m_row  = 0;
          m_band = (m_band == 2) ? 0 : m_band + 1;
        end else begin
          m_row++;
        end
      end else begin
        m_col++;
      end
    end else begin
      exp_stb = 0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pix_en = 1'b1; active = 1'b1; frame_start = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    exp_stb = 0; exp_addr = 0; exp_band = 0;
    m_row = 0; m_band = 0; m_col = 0;
    cmp("R1 reset");
    @(negedge clk);
    pix_en = 1'b0; active = 1'b0;
    rst_n = 1'b1;
    step(0, 0, 0);
    cmp("R1 after release");
  endtask

  task automatic t_line_walk();
    step(0, 0, 1);
    cmp("R7 frame start");
    for (int i = 0; i < 40; i++) begin
      step(1, 1, 0);
      cmp("R3 line walk");
      step(i % 2 == 0, 1, 0);
      cmp("R2 gapped fetch");
    end
    step(1, 1, 0);
    cmp("R4 next line");
    chk("R4 second line start", int'(mem_addr) % 128, exp_addr % 128);
  endtask

  task automatic t_hold();
    int held = int'(mem_addr);
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0);
      cmp("R8 active low");
      chk("R8 addr held", int'(mem_addr), held);
    end
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0);
      cmp("R8 enable low");
    end
    step(1, 1, 0);
    cmp("R8 resume");
  endtask

  task automatic t_full_frame();
    step(0, 0, 1);
    for (int i = 0; i < 7680; i++) begin
      step(1, 1, 0);
      if (i == 2560 || i == 5120) begin
        cmp("R5 band boundary");
        chk("R5 band offset", int'(mem_addr), (i / 2560) * 40);
      end else if (i == 7679) begin
        cmp("R6 last byte");
        chk("R6 last address", int'(mem_addr), 8183);
      end else begin
        cmp("R3 frame");
      end
      if (int'(mem_addr) % 128 > 119) chk("R9 row slice", int'(mem_addr) % 128, 119);
    end
    step(1, 1, 0);
    cmp("R6 wrap");
    chk("R6 wrap address", int'(mem_addr), 0);
  endtask

  task automatic t_collision();
    int held;
    for (int i = 0; i < 17; i++) step(1, 1, 0);
    held = int'(mem_addr);
    step(1, 1, 1);
    cmp("R7 collision");
    chk("R7 no strobe", int'(fetch_stb), 0);
    chk("R7 addr held", int'(mem_addr), held);
    step(1, 1, 0);
    cmp("R7 restart");
    chk("R7 restart address", int'(mem_addr), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_line_walk();
    t_hold();
    t_full_frame();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule